// File: doc/BRIEF.md
# Code and External Data Address Router

This block sits between the CPU core of a small 8-bit microcontroller and its memories. It decodes two kinds of 16-bit access. An instruction fetch goes either to the on-chip program ROM or to the external bus. A data move into the external data space goes either to a small on-chip XRAM or to the external bus. Each access is answered in the same cycle by a chip select or by an external-bus request. One cycle later the router returns the read byte from the source that was selected.

Fetch routing is controlled by a strap pin. The router captures the pin only while reset is held. With the strap high, the lower 32 KB of code space is served on chip and the upper half goes out on the bus. With the strap low, every fetch goes out on the bus. A 1 KB XRAM window covers the top of the 64 KB external data space. Data accesses take either a full 16-bit address or an 8-bit short address. In the short form the upper byte comes from a page input. The core must never present a fetch and a data access in the same cycle. If it does, the router flags a protocol error and routes neither access.

Top module: `mem_route_top`

## Requirements
- R1: With the captured strap at 1, a fetch whose address is below 8000H raises `rom_cs_o` only, and `int_addr_o` equals the fetch address.
- R2: With the captured strap at 1, a fetch at 8000H or above raises `ext_req_o` only, with `ext_addr_o` equal to the fetch address and `ext_is_data_o` and `ext_we_o` at 0.
- R3: With the captured strap at 0, every fetch, including those below 8000H, raises `ext_req_o` and never `rom_cs_o`.
- R4: The strap is captured on each clock edge at which `rst_n` is 0. Changes on the strap pin while `rst_n` is 1 have no effect on routing until the next reset.
- R5: A 16-bit data access at FC00H or above raises `xram_cs_o`, and `int_addr_o` equals the address minus FC00H. Any lower address raises `ext_req_o` with `ext_is_data_o` at 1, `ext_addr_o` equal to the address, and `ext_we_o` equal to `data_we_i`.
- R6: When `data_short_i` is 1, the effective data address is `data_page_i` as the upper byte and `data_addr_i[7:0]` as the lower byte, and it is routed as in R5. `data_addr_i[15:8]` is ignored.
- R7: When a fetch and a data access are both requested in one cycle, `proto_err_o` is 1, no chip select or bus request is raised, and no read data is returned in the next cycle.
- R8: One cycle after an accepted fetch or data read, `rvalid_o` is 1 and `rdata_o` carries the read input of the source that was selected (ROM, XRAM or external). After a write, after an idle cycle, or after a rejected cycle, `rvalid_o` is 0.
- R9: While `rst_n` is 0, `rom_cs_o`, `xram_cs_o`, `ext_req_o` and `proto_err_o` are 0 whatever the requests are, and from the first clock edge of reset `rvalid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_i | input | 1 | External-access strap pin, captured during reset |
| fetch_req_i | input | 1 | Instruction fetch request |
| fetch_addr_i | input | 16 | Fetch address |
| data_req_i | input | 1 | External data space access request |
| data_we_i | input | 1 | Data access is a write |
| data_short_i | input | 1 | Data access uses the 8-bit address form |
| data_addr_i | input | 16 | Data address (only the low byte is used in short form) |
| data_page_i | input | 8 | Upper address byte for the short form |
| rom_rdata_i | input | 8 | Read byte from the on-chip ROM |
| xram_rdata_i | input | 8 | Read byte from the on-chip XRAM |
| ext_rdata_i | input | 8 | Read byte from the external bus |
| rom_cs_o | output | 1 | On-chip ROM select |
| xram_cs_o | output | 1 | On-chip XRAM select |
| int_addr_o | output | 16 | Offset into the selected on-chip memory |
| ext_req_o | output | 1 | External bus request |
| ext_addr_o | output | 16 | External bus address |
| ext_is_data_o | output | 1 | External request is a data access rather than a fetch |
| ext_we_o | output | 1 | External request is a write |
| proto_err_o | output | 1 | Fetch and data requested together |
| rdata_o | output | 8 | Returned read byte |
| rvalid_o | output | 1 | `rdata_o` is valid |

## Verification
Two events fall in the same cycle. The routing of a new request is combinational, and the data return of the previous request comes from a registered select. The bench sends requests back to back with no idle cycles, switching between ROM, XRAM and external targets. The read inputs hold distinct constant values, so a return taken from the wrong source shows up as a wrong byte. The second collision is a fetch and a data access raised together. It is judged by the error flag, by the absence of every select and request in that cycle, and by the absence of a return in the cycle after.

// File: rtl/mem_route_pkg.sv
// Package: shared types for the code/data address router.
// Assumes nothing beyond the users importing it.
package mem_route_pkg;

    // Source of the byte returned one cycle after an access
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_ROM  = 2'd1,
        SRC_XRAM = 2'd2,
        SRC_EXT  = 2'd3
    } rd_src_e;

endpackage

// File: rtl/mr_fetch_decode.sv
// Fetch decoder: says whether a code address is served by the on-chip ROM.
// Assumes the ROM occupies code space from address zero upward and that
// strap_q is the captured external-access strap (1 = on-chip ROM enabled).
module mr_fetch_decode #(
    parameter int ADDR_W    = 16,
    parameter int ROM_BYTES = 32768
) (
    input  logic              strap_q,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_rom_o
);

    localparam logic [ADDR_W:0] ROM_LIMIT = (ADDR_W+1)'(ROM_BYTES);

    // ROM hit when enabled by strap and the address lies below the ROM limit
    always_comb begin
        hit_rom_o = strap_q && ({1'b0, addr_i} < ROM_LIMIT);
    end

endmodule

// File: rtl/mr_data_decode.sv
// Data decoder: forms the effective external-data address (full or short
// form) and says whether it falls in the on-chip XRAM window at the top.
// Assumes the window size is a power of two and ends at the top of space.
module mr_data_decode #(
    parameter int ADDR_W     = 16,
    parameter int SHORT_W    = 8,
    parameter int XRAM_BYTES = 1024
) (
    input  logic                      short_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [ADDR_W-SHORT_W-1:0] page_i,
    output logic [ADDR_W-1:0]         eff_addr_o,
    output logic                      hit_xram_o,
    output logic [ADDR_W-1:0]         xram_off_o
);

    localparam int                XRAM_BASE_I = (1 << ADDR_W) - XRAM_BYTES;
    localparam logic [ADDR_W-1:0] XRAM_BASE   = XRAM_BASE_I[ADDR_W-1:0];

    // Effective address: page byte on top for the short form
    always_comb begin
        if (short_i) begin
            eff_addr_o = {page_i, addr_i[SHORT_W-1:0]};
        end else begin
            eff_addr_o = addr_i;
        end
    end

    // Window hit and offset into the XRAM
    always_comb begin
        hit_xram_o = (eff_addr_o >= XRAM_BASE);
        xram_off_o = eff_addr_o - XRAM_BASE;
    end

endmodule

// File: rtl/mr_rdata_return.sv
// Read return: registers which source an accepted read targeted and, in the
// following cycle, steers that source's read byte to the output.
// Assumes at most one of the select strobes is high per cycle.
module mr_rdata_return
    import mem_route_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_rom_i,
    input  logic              rd_xram_i,
    input  logic              rd_ext_i,
    input  logic [DATA_W-1:0] rom_rdata_i,
    input  logic [DATA_W-1:0] xram_rdata_i,
    input  logic [DATA_W-1:0] ext_rdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);

    rd_src_e src_q;
    rd_src_e src_d;

    // Encode the read source for this cycle
    always_comb begin
        if (rd_rom_i) begin
            src_d = SRC_ROM;
        end else if (rd_xram_i) begin
            src_d = SRC_XRAM;
        end else if (rd_ext_i) begin
            src_d = SRC_EXT;
        end else begin
            src_d = SRC_NONE;
        end
    end

    // Hold the source for one cycle; cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= SRC_NONE;
        end else begin
            src_q <= src_d;
        end
    end

    // Return mux driven by the registered source
    always_comb begin
        rvalid_o = (src_q != SRC_NONE);
        unique case (src_q)
            SRC_ROM:  rdata_o = rom_rdata_i;
            SRC_XRAM: rdata_o = xram_rdata_i;
            SRC_EXT:  rdata_o = ext_rdata_i;
            default:  rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/mem_route_top.sv
// Code and external-data router. Routes each fetch to on-chip ROM or the
// external bus (by captured strap and ROM size), each data access to the
// on-chip XRAM window or the external bus, and returns read data one cycle
// later. Assumes the core never raises fetch and data requests together;
// if it does, both are dropped and proto_err_o is raised.
module mem_route_top #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int SHORT_W    = 8,
    parameter int ROM_BYTES  = 32768,
    parameter int XRAM_BYTES = 1024
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      strap_i,
    input  logic                      fetch_req_i,
    input  logic [ADDR_W-1:0]         fetch_addr_i,
    input  logic                      data_req_i,
    input  logic                      data_we_i,
    input  logic                      data_short_i,
    input  logic [ADDR_W-1:0]         data_addr_i,
    input  logic [ADDR_W-SHORT_W-1:0] data_page_i,
    input  logic [DATA_W-1:0]         rom_rdata_i,
    input  logic [DATA_W-1:0]         xram_rdata_i,
    input  logic [DATA_W-1:0]         ext_rdata_i,
    output logic                      rom_cs_o,
    output logic                      xram_cs_o,
    output logic [ADDR_W-1:0]         int_addr_o,
    output logic                      ext_req_o,
    output logic [ADDR_W-1:0]         ext_addr_o,
    output logic                      ext_is_data_o,
    output logic                      ext_we_o,
    output logic                      proto_err_o,
    output logic [DATA_W-1:0]         rdata_o,
    output logic                      rvalid_o
);

    logic              strap_q;
    logic              fetch_ok;
    logic              data_ok;
    logic              f_hit_rom;
    logic              d_hit_xram;
    logic [ADDR_W-1:0] d_eff_addr;
    logic [ADDR_W-1:0] d_xram_off;
    logic              rd_rom;
    logic              rd_xram;
    logic              rd_ext;

    // Capture the strap on every reset edge; hold it afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q <= strap_i;
        end
    end

    // Accept exactly one request kind per cycle, nothing during reset
    always_comb begin
        fetch_ok    = rst_n && fetch_req_i && !data_req_i;
        data_ok     = rst_n && data_req_i && !fetch_req_i;
        proto_err_o = rst_n && fetch_req_i && data_req_i;
    end

    mr_fetch_decode #(
        .ADDR_W    (ADDR_W),
        .ROM_BYTES (ROM_BYTES)
    ) u_fetch (
        .strap_q   (strap_q),
        .addr_i    (fetch_addr_i),
        .hit_rom_o (f_hit_rom)
    );

    mr_data_decode #(
        .ADDR_W     (ADDR_W),
        .SHORT_W    (SHORT_W),
        .XRAM_BYTES (XRAM_BYTES)
    ) u_data (
        .short_i    (data_short_i),
        .addr_i     (data_addr_i),
        .page_i     (data_page_i),
        .eff_addr_o (d_eff_addr),
        .hit_xram_o (d_hit_xram),
        .xram_off_o (d_xram_off)
    );

    // Drive selects, bus request and addresses for the accepted access
    always_comb begin
        rom_cs_o      = fetch_ok && f_hit_rom;
        xram_cs_o     = data_ok && d_hit_xram;
        ext_is_data_o = data_ok && !d_hit_xram;
        ext_req_o     = (fetch_ok && !f_hit_rom) || ext_is_data_o;
        ext_we_o      = ext_is_data_o && data_we_i;
        ext_addr_o    = fetch_ok ? fetch_addr_i : d_eff_addr;
        int_addr_o    = fetch_ok ? fetch_addr_i : d_xram_off;
    end

    // Read strobes: every fetch reads, data reads only when not writing
    always_comb begin
        rd_rom  = rom_cs_o;
        rd_xram = xram_cs_o && !data_we_i;
        rd_ext  = ext_req_o && !ext_we_o;
    end

    mr_rdata_return #(
        .DATA_W (DATA_W)
    ) u_ret (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_rom_i     (rd_rom),
        .rd_xram_i    (rd_xram),
        .rd_ext_i     (rd_ext),
        .rom_rdata_i  (rom_rdata_i),
        .xram_rdata_i (xram_rdata_i),
        .ext_rdata_i  (ext_rdata_i),
        .rdata_o      (rdata_o),
        .rvalid_o     (rvalid_o)
    );

endmodule

// File: rtl/mem_route_chk.sv
// Checker for mem_route_top: temporal properties on the router's ports and
// its captured strap. Attached by the bind statement at the end of the file.
module mem_route_chk (
    input logic clk,
    input logic rst_n,
    input logic strap_q,
    input logic fetch_req_i,
    input logic data_req_i,
    input logic data_we_i,
    input logic rom_cs_o,
    input logic xram_cs_o,
    input logic ext_req_o,
    input logic proto_err_o,
    input logic rvalid_o
);

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_cs_o, xram_cs_o, ext_req_o}));                               // R7

    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |-> !rom_cs_o && !xram_cs_o && !ext_req_o);                    // R7

    AST_ERR_NO_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_i && data_req_i) |=> !rvalid_o);                                // R7

    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strap_q));                                        // R4

    AST_NOSTRAP_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_i && !data_req_i && !strap_q) |-> ext_req_o && !rom_cs_o);      // R3

    AST_XRAM_ONLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        xram_cs_o |-> data_req_i && !fetch_req_i);                                 // R5

    AST_FETCH_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_i && !data_req_i) |=> rvalid_o);                                // R8

    AST_WRITE_NO_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (data_req_i && data_we_i && !fetch_req_i) |=> !rvalid_o);                  // R8

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> !rom_cs_o && !xram_cs_o && !ext_req_o && !proto_err_o);         // R9

endmodule

bind mem_route_top mem_route_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap_q     (strap_q),
    .fetch_req_i (fetch_req_i),
    .data_req_i  (data_req_i),
    .data_we_i   (data_we_i),
    .rom_cs_o    (rom_cs_o),
    .xram_cs_o   (xram_cs_o),
    .ext_req_o   (ext_req_o),
    .proto_err_o (proto_err_o),
    .rvalid_o    (rvalid_o)
);

// File: tb/tb_mem_route_top.sv
// Scoreboard bench: the driver computes expected routing and return per
// cycle and queues it; the monitor pops and compares away from the edge.
module tb_mem_route_top;

    localparam logic [7:0] ROM_BYTE  = 8'h11;
    localparam logic [7:0] XRAM_BYTE = 8'h22;
    localparam logic [7:0] EXT_BYTE  = 8'h33;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_i = 1'b1;
    logic        fetch_req_i = 1'b0;
    logic [15:0] fetch_addr_i = '0;
    logic        data_req_i = 1'b0;
    logic        data_we_i = 1'b0;
    logic        data_short_i = 1'b0;
    logic [15:0] data_addr_i = '0;
    logic [7:0]  data_page_i = '0;
    logic [7:0]  rom_rdata_i = ROM_BYTE;
    logic [7:0]  xram_rdata_i = XRAM_BYTE;
    logic [7:0]  ext_rdata_i = EXT_BYTE;
    logic        rom_cs_o, xram_cs_o, ext_req_o, ext_is_data_o, ext_we_o, proto_err_o, rvalid_o;
    logic [15:0] int_addr_o, ext_addr_o;
    logic [7:0]  rdata_o;

    always #5 clk = ~clk;

    mem_route_top dut (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_i),
        .fetch_req_i(fetch_req_i), .fetch_addr_i(fetch_addr_i),
        .data_req_i(data_req_i), .data_we_i(data_we_i), .data_short_i(data_short_i),
        .data_addr_i(data_addr_i), .data_page_i(data_page_i),
        .rom_rdata_i(rom_rdata_i), .xram_rdata_i(xram_rdata_i), .ext_rdata_i(ext_rdata_i),
        .rom_cs_o(rom_cs_o), .xram_cs_o(xram_cs_o), .int_addr_o(int_addr_o),
        .ext_req_o(ext_req_o), .ext_addr_o(ext_addr_o), .ext_is_data_o(ext_is_data_o),
        .ext_we_o(ext_we_o), .proto_err_o(proto_err_o), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
    );

    typedef struct {
        string       tag;
        logic [5:0]  flags;   // rom, xram, ext, is_data, we, err
        logic [15:0] addr;    // int_addr when a cs is up, ext_addr on ext, else 0
        logic        rv;
        logic [7:0]  rd;
    } item_t;

    item_t scb_q[$];
    int    n_checks = 0;
    int    n_fail = 0;
    logic  strap_model = 1'b0;
    bit    done = 1'b0;

    // Driver: apply one cycle of stimulus and queue its expectations
    task automatic access(input string tag, input logic rst, input logic strap,
                          input logic freq, input logic [15:0] faddr,
                          input logic dreq, input logic dwe, input logic dshort,
                          input logic [15:0] daddr, input logic [7:0] page);
        item_t it;
        logic  f_ok, d_ok, rom, xr, ext;
        logic [15:0] eff;
        @(negedge clk);
        rst_n = rst; strap_i = strap; fetch_req_i = freq; fetch_addr_i = faddr;
        data_req_i = dreq; data_we_i = dwe; data_short_i = dshort;
        data_addr_i = daddr; data_page_i = page;
        f_ok = rst && freq && !dreq;
        d_ok = rst && dreq && !freq;
        eff  = dshort ? {page, daddr[7:0]} : daddr;
        rom  = f_ok && strap_model && (faddr < 16'h8000);
        xr   = d_ok && (eff >= 16'hFC00);
        ext  = (f_ok && !rom) || (d_ok && !xr);
        it.tag   = tag;
        it.flags = {rom, xr, ext, d_ok && !xr, d_ok && !xr && dwe, rst && freq && dreq};
        it.addr  = rom ? faddr : xr ? (eff - 16'hFC00) : ext ? (f_ok ? faddr : eff) : 16'h0;
        it.rv    = rom || (xr && !dwe) || (ext && !(d_ok && dwe));
        it.rd    = rom ? ROM_BYTE : xr ? XRAM_BYTE : EXT_BYTE;
        scb_q.push_back(it);
        if (!rst) strap_model = strap;
    endtask

    task automatic fetch(input string tag, input logic [15:0] a, input logic strap);
        access(tag, 1'b1, strap, 1'b1, a, 1'b0, 1'b0, 1'b0, 16'h0, 8'h0);
    endtask

    task automatic dacc(input string tag, input logic we, input logic sh,
                        input logic [15:0] a, input logic [7:0] pg);
        access(tag, 1'b1, strap_model, 1'b0, 16'h0, 1'b1, we, sh, a, pg);
    endtask

    task automatic idle(input string tag);
        access(tag, 1'b1, strap_model, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0, 8'h0);
    endtask

    // Monitor: compare routing this cycle and the return owed from last cycle
    initial begin
        item_t pend;
        bit    pend_v = 1'b0;
        forever begin
            @(negedge clk);
            #3;
            if (scb_q.size() > 0) begin
                item_t it;
                logic [5:0]  act_f;
                logic [15:0] act_a;
                it = scb_q.pop_front();
                if (pend_v) begin
                    n_checks++;
                    if (rvalid_o !== pend.rv || (pend.rv && rdata_o !== pend.rd)) begin
                        n_fail++;
                        $display("FAIL %s return: actual rv=%b rd=%h expected rv=%b rd=%h",
                                 pend.tag, rvalid_o, rdata_o, pend.rv, pend.rd);
                    end
                end
                act_f = {rom_cs_o, xram_cs_o, ext_req_o, ext_is_data_o, ext_we_o, proto_err_o};
                act_a = (rom_cs_o || xram_cs_o) ? int_addr_o : ext_req_o ? ext_addr_o : 16'h0;
                n_checks++;
                if (act_f !== it.flags || act_a !== it.addr) begin
                    n_fail++;
                    $display("FAIL %s route: actual flags=%b addr=%h expected flags=%b addr=%h",
                             it.tag, act_f, act_a, it.flags, it.addr);
                end
                pend   = it;
                pend_v = 1'b1;
            end else begin
                pend_v = 1'b0;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Stimulus sequence
    initial begin
        @(posedge clk);
        // R9: requests held during reset are not routed; strap=1 captured
        access("R9_reset", 1'b0, 1'b1, 1'b1, 16'h0010, 1'b0, 1'b0, 1'b0, 16'h0, 8'h0);
        access("R9_reset_both", 1'b0, 1'b1, 1'b1, 16'h0010, 1'b1, 1'b0, 1'b0, 16'hFC00, 8'h0);
        access("R9_reset_data", 1'b0, 1'b1, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0, 16'hFC00, 8'h0);
        // R1 / R2 with strap 1, back to back so returns overlap new routes (R8)
        fetch("R1_low0", 16'h0000, 1'b1);
        fetch("R1_top", 16'h7FFF, 1'b1);
        fetch("R2_bottom", 16'h8000, 1'b1);
        fetch("R2_top", 16'hFFFF, 1'b1);
        // R5 full-width data
        dacc("R5_below_window", 1'b0, 1'b0, 16'hFBFF, 8'h00);
        dacc("R5_window_base", 1'b0, 1'b0, 16'hFC00, 8'h00);
        dacc("R5_window_write", 1'b1, 1'b0, 16'hFFFF, 8'h00);
        dacc("R5_ext_write", 1'b1, 1'b0, 16'h1234, 8'h00);
        fetch("R8_after_write", 16'h0100, 1'b1);
        // R6 short form: page supplies the upper byte, data_addr_i[15:8] ignored
        dacc("R6_short_xram", 1'b0, 1'b1, 16'h0005, 8'hFC);
        dacc("R6_short_ext", 1'b0, 1'b1, 16'hFF05, 8'h12);
        dacc("R6_short_top", 1'b1, 1'b1, 16'h00FF, 8'hFF);
        // R7 collision, then idle (R8)
        access("R7_both", 1'b1, 1'b1, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 16'hFC00, 8'h0);
        idle("R8_idle");
        // R4: strap pin dropped after reset has no effect
        fetch("R4_pin_low_ignored", 16'h0000, 1'b0);
        fetch("R4_pin_low_ignored2", 16'h7000, 1'b0);
        // New reset with strap 0
        access("R9_reset2", 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0, 8'h0);
        access("R9_reset2b", 1'b0, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0, 8'h0);
        fetch("R3_low0", 16'h0000, 1'b0);
        fetch("R3_top_half", 16'h7FFF, 1'b0);
        fetch("R4_pin_high_ignored", 16'h0010, 1'b1);
        dacc("R5_under_strap0", 1'b0, 1'b0, 16'hFE00, 8'h00);
        fetch("R3_high", 16'hC000, 1'b1);
        idle("R8_idle_end");
        idle("R8_idle_end2");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule